// File: doc/BRIEF.md
# ATA PIO and Multiword DMA Cycle Sequencer

This block is the host end of one parallel ATA channel for register (PIO) transfers and multiword DMA transfers. A requester presents one transfer at a time: direction, a DMA flag, a 3-bit register offset, a choice between the command-block and control-block chip select, and 16-bit write data. The block then runs the bus cycle on the device pins. It drives the address lines, the two active-low chip selects, the active-low read and write strobes and the active-low DMA acknowledge. It controls the shared data bus through a drive-enable and samples the device's ready and DMA-request lines.

Each cycle has three timed phases, each programmed in clock cycles: address setup before the strobe, strobe active time, and recovery after the strobe. A programmed zero counts as one cycle. A register cycle selects the device through a chip select and the address. A DMA cycle leaves both chip selects high and marks the strobe with the acknowledge instead. In register cycles the device can stretch the strobe by holding ready low. Read data is taken on the edge where the read strobe rises. A one-cycle completion pulse, with the read data, marks the end of the cycle, and a busy flag keeps out new requests until then.

The state machine has five states: `ST_IDLE`, `ST_SETUP`, `ST_ACTIVE`, `ST_RECOVER` and `ST_DONE`. The transitions are:

- **accept**: `ST_IDLE` to `ST_SETUP`, when `req_valid` is high and the request is either not DMA or `dev_dmarq` is high.
- **strobe_on**: `ST_SETUP` to `ST_ACTIVE`, when the setup count expires.
- **strobe_off**: `ST_ACTIVE` to `ST_RECOVER`, when the active count has expired and either the synchronized ready is high or the cycle is DMA.
- **recovered**: `ST_RECOVER` to `ST_DONE`, when the recovery count expires.
- **retire**: `ST_DONE` to `ST_IDLE`, unconditionally.

Top module: `ata_cycle_seq`

## Requirements
- R1: During and after reset, both strobes, both chip selects and the DMA acknowledge are high, `dd_oe` is 0, and `busy` and `done` are 0.
- R2: A register cycle drives `dev_addr` from the request from setup through recovery. With `req_blk`=0, `dev_cs0_n` is low; with `req_blk`=1, `dev_cs1_n` is low. The other chip select and `dev_dmack_n` stay high.
- R3: With setup S, active A and recovery R (each value 0 taken as 1), the strobe is low for exactly A cycles when ready is high. `done` is seen in the (S+A+R+1)th cycle after the accepting clock edge.
- R4: A read returns on `rdata` the value of `dd_in` at the clock edge where the read strobe rises, not its value at the falling edge.
- R5: A write drives `dd_out` equal to the request data while the write strobe is low. `dd_oe` is high from the start of setup until one clock after the write strobe rises, which is S+A+1 cycles. `dd_oe` is never high on a read.
- R6: In a register cycle, while the synchronized `dev_iordy` is low, the strobe stays low past its active count. It rises after `dev_iordy` returns high.
- R7: A DMA cycle holds `dev_dmack_n` low from setup through recovery and keeps both chip selects high. `dev_iordy` has no effect on its timing.
- R8: A DMA request is not started while `dev_dmarq` is low. It starts once `dev_dmarq` goes high.
- R9: `done` is a single-cycle pulse. `busy` is high from the accepting edge through the `done` cycle. A request presented while busy is ignored.
- R10: The read and write strobes are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dma | input | 1 | 1 = DMA cycle |
| req_blk | input | 1 | 0 = command block select, 1 = control block select |
| req_addr | input | 3 | Register offset |
| req_wdata | input | 16 | Write data |
| t_setup | input | 8 | Setup time in clocks |
| t_active | input | 8 | Minimum strobe time in clocks |
| t_recover | input | 8 | Recovery time in clocks |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | Completion pulse |
| rdata | output | 16 | Captured read data |
| dev_addr | output | 3 | Device address |
| dev_cs0_n | output | 1 | Command block select, active low |
| dev_cs1_n | output | 1 | Control block select, active low |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_dmack_n | output | 1 | DMA acknowledge, active low |
| dev_dmarq | input | 1 | Device DMA request |
| dev_iordy | input | 1 | Device ready |
| dd_in | input | 16 | Data bus input |
| dd_out | output | 16 | Data bus output |
| dd_oe | output | 1 | Data bus drive-enable |

## Verification
The bench applies a request at a falling edge and counts falling-edge samples after the accepting rising edge. `done` is due at sample S+A+R+1, and the strobe and drive-enable are tallied sample by sample against A and S+A+1. Read data is compared once `done` is seen, since it was latched at the strobe-rise edge S+A edges after acceptance. The ready-stretch test changes `dd_in` only at the moment ready is raised, so data held from the strobe's falling edge would miscompare. The DMA hold-off test waits a fixed number of samples before checking that nothing has started.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_RECOVER,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/ata_phase_timer.sv
module ata_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= ONE;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? ONE : load_val;
        end else if (cnt_q > ONE) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign expired = (cnt_q == ONE);
endmodule

// File: rtl/ata_bit_sync.sv
module ata_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ata_cycle_seq.sv
module ata_cycle_seq
    import ata_seq_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_dma,
    input  logic              req_blk,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  t_setup,
    input  logic [CNT_W-1:0]  t_active,
    input  logic [CNT_W-1:0]  t_recover,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              dev_cs0_n,
    output logic              dev_cs1_n,
    output logic              dev_rd_n,
    output logic              dev_wr_n,
    output logic              dev_dmack_n,
    input  logic              dev_dmarq,
    input  logic              dev_iordy,
    input  logic [DATA_W-1:0] dd_in,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe
);
    localparam int SYNC_STAGES = 2;

    seq_state_t state_q, state_d;

    logic              q_write, q_dma, q_blk;
    logic [ADDR_W-1:0] q_addr;
    logic [DATA_W-1:0] q_wdata;
    logic              oe_tail_q;

    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_exp;
    logic              iordy_s;
    logic              accept, strobe_end;

    ata_bit_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (dev_iordy),
        .q     (iordy_s)
    );

    ata_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    assign accept     = (state_q == ST_IDLE) && req_valid && (!req_dma || dev_dmarq);
    assign strobe_end = (state_q == ST_ACTIVE) && tmr_exp && (q_dma || iordy_s);

    // next state and timer load
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = t_setup;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = t_setup;
                end
            end
            ST_SETUP: begin
                if (tmr_exp) begin
                    state_d  = ST_ACTIVE;
                    tmr_load = 1'b1;
                    tmr_val  = t_active;
                end
            end
            ST_ACTIVE: begin
                if (strobe_end) begin
                    state_d  = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = t_recover;
                end
            end
            ST_RECOVER: begin
                if (tmr_exp) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            q_write   <= 1'b0;
            q_dma     <= 1'b0;
            q_blk     <= 1'b0;
            q_addr    <= '0;
            q_wdata   <= '0;
            rdata     <= '0;
            oe_tail_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            oe_tail_q <= strobe_end && q_write;
            if (accept) begin
                q_write <= req_write;
                q_dma   <= req_dma;
                q_blk   <= req_blk;
                q_addr  <= req_addr;
                q_wdata <= req_wdata;
            end
            if (strobe_end && !q_write) begin
                rdata <= dd_in;
            end
        end
    end

    // pin outputs decoded from state
    always_comb begin
        logic in_cycle;
        in_cycle    = (state_q == ST_SETUP) || (state_q == ST_ACTIVE) ||
                      (state_q == ST_RECOVER);
        busy        = (state_q != ST_IDLE);
        done        = (state_q == ST_DONE);
        dev_addr    = (in_cycle && !q_dma) ? q_addr : '0;
        dev_cs0_n   = !(in_cycle && !q_dma && !q_blk);
        dev_cs1_n   = !(in_cycle && !q_dma && q_blk);
        dev_dmack_n = !(in_cycle && q_dma);
        dev_rd_n    = !((state_q == ST_ACTIVE) && !q_write);
        dev_wr_n    = !((state_q == ST_ACTIVE) && q_write);
        dd_out      = q_wdata;
        dd_oe       = q_write && ((state_q == ST_SETUP) ||
                                  (state_q == ST_ACTIVE) || oe_tail_q);
    end
endmodule

// File: rtl/ata_cycle_seq_chk.sv
module ata_cycle_seq_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] dev_addr,
    input logic              dev_cs0_n,
    input logic              dev_cs1_n,
    input logic              dev_rd_n,
    input logic              dev_wr_n,
    input logic              dev_dmack_n,
    input logic              dd_oe
);
    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dev_rd_n && !dev_wr_n));

    assert_dmack_no_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_dmack_n |-> (dev_cs0_n && dev_cs1_n));

    assert_single_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dev_cs0_n && !dev_cs1_n));

    assert_no_oe_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dd_oe |-> dev_rd_n);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_in_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_rd_n || !dev_wr_n) |-> busy);

    assert_addr_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_rd_n && !$past(dev_rd_n)) |-> $stable(dev_addr));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dev_rd_n && dev_wr_n && dev_dmack_n && !dd_oe));
endmodule

bind ata_cycle_seq ata_cycle_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .dev_addr    (dev_addr),
    .dev_cs0_n   (dev_cs0_n),
    .dev_cs1_n   (dev_cs1_n),
    .dev_rd_n    (dev_rd_n),
    .dev_wr_n    (dev_wr_n),
    .dev_dmack_n (dev_dmack_n),
    .dd_oe       (dd_oe)
);

// File: tb/test_ata_cycle_seq.sv
module test_ata_cycle_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0, req_dma = 0, req_blk = 0;
    logic [2:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [7:0]  t_setup = 8'd1, t_active = 8'd1, t_recover = 8'd1;
    logic        busy, done;
    logic [15:0] rdata;
    logic [2:0]  dev_addr;
    logic        dev_cs0_n, dev_cs1_n, dev_rd_n, dev_wr_n, dev_dmack_n;
    logic        dev_dmarq = 1'b0, dev_iordy = 1'b1;
    logic [15:0] dd_in = '0;
    logic [15:0] dd_out;
    logic        dd_oe;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    ata_cycle_seq i_ata_cycle_seq (.*);

    // {write, dma, blk, addr[2:0], data[15:0], ts[3:0], ta[3:0], tr[3:0]}
    localparam int NV = 12;
    localparam logic [33:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 3'd7, 16'hA5C3, 4'd1, 4'd1, 4'd1},
        {1'b1, 1'b0, 1'b0, 3'd2, 16'h1234, 4'd2, 4'd3, 4'd2},
        {1'b0, 1'b0, 1'b1, 3'd6, 16'hBEEF, 4'd3, 4'd4, 4'd1},
        {1'b1, 1'b0, 1'b1, 3'd6, 16'h0F0F, 4'd1, 4'd5, 4'd3},
        {1'b0, 1'b0, 1'b0, 3'd0, 16'h8001, 4'd0, 4'd0, 4'd0},
        {1'b1, 1'b0, 1'b0, 3'd5, 16'hFFFF, 4'd0, 4'd2, 4'd0},
        {1'b0, 1'b1, 1'b0, 3'd3, 16'h5A5A, 4'd2, 4'd2, 4'd2},
        {1'b1, 1'b1, 1'b0, 3'd1, 16'hC0DE, 4'd1, 4'd3, 4'd1},
        {1'b0, 1'b1, 1'b1, 3'd4, 16'h0001, 4'd4, 4'd1, 4'd4},
        {1'b1, 1'b1, 1'b0, 3'd0, 16'h7E7E, 4'd0, 4'd0, 4'd0},
        {1'b0, 1'b0, 1'b1, 3'd1, 16'h3C3C, 4'd5, 4'd6, 4'd5},
        {1'b1, 1'b0, 1'b0, 3'd3, 16'h0000, 4'd2, 4'd1, 4'd6}
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // one transfer with per-sample monitoring; returns sample index of done
    task automatic run_cycle(input logic w, input logic d, input logic b,
                             input logic [2:0] a, input logic [15:0] data,
                             input int ts, input int ta, input int tr,
                             output int done_at, output int str_n,
                             output int oe_n, output int sel_bad);
        int tot;
        tot = eff(ts) + eff(ta) + eff(tr);
        t_setup = 8'(ts); t_active = 8'(ta); t_recover = 8'(tr);
        req_write = w; req_dma = d; req_blk = b; req_addr = a; req_wdata = data;
        dd_in = data; dev_dmarq = d;
        req_valid = 1'b1;
        done_at = 0; str_n = 0; oe_n = 0; sel_bad = 0;
        for (int k = 1; k <= 80; k++) begin
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            if (!dev_rd_n || !dev_wr_n) str_n++;
            if (dd_oe) oe_n++;
            if (!dev_wr_n && dd_out != data) sel_bad++;
            if (k <= tot) begin
                if (d) begin
                    if (dev_dmack_n || !dev_cs0_n || !dev_cs1_n) sel_bad++;
                end else begin
                    if (!dev_dmack_n || dev_addr != a) sel_bad++;
                    if (dev_cs0_n != b || dev_cs1_n != !b) sel_bad++;
                end
            end
            if (done) begin
                done_at = k;
                break;
            end
        end
        dev_dmarq = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int da, sn, on, sb, tot;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(dev_rd_n && dev_wr_n && dev_cs0_n && dev_cs1_n && dev_dmack_n && !dd_oe
            && !busy && !done, "R1 reset pins", {dev_rd_n, dev_wr_n, dev_cs0_n,
            dev_cs1_n, dev_dmack_n, dd_oe, busy, done}, 8'b11111000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && dev_rd_n && dev_wr_n, "R1 after reset idle", busy, 0);

        // vector table: R2 R3 R4 R5 R7
        for (int i = 0; i < NV; i++) begin
            logic [33:0] v;
            v = VEC[i];
            run_cycle(v[33], v[32], v[31], v[30:28], v[27:12],
                      int'(v[11:8]), int'(v[7:4]), int'(v[3:0]), da, sn, on, sb);
            tot = eff(int'(v[11:8])) + eff(int'(v[7:4])) + eff(int'(v[3:0]));
            chk(da == tot + 1, "R3 done timing", da, tot + 1);
            chk(sn == eff(int'(v[7:4])), "R3 strobe width", sn, eff(int'(v[7:4])));
            chk(sb == 0, v[32] ? "R7 DMA select" : "R2 register select", sb, 0);
            if (v[33])
                chk(on == eff(int'(v[11:8])) + eff(int'(v[7:4])) + 1,
                    "R5 drive window", on, eff(int'(v[11:8])) + eff(int'(v[7:4])) + 1);
            else begin
                chk(on == 0, "R5 no drive on read", on, 0);
                chk(rdata == v[27:12], "R4 read data", rdata, v[27:12]);
            end
        end

        // R6 ready stretch and R4 capture at strobe rise
        t_setup = 8'd1; t_active = 8'd2; t_recover = 8'd1;
        req_write = 0; req_dma = 0; req_blk = 0; req_addr = 3'd4;
        dd_in = 16'h1111; dev_iordy = 1'b0; req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        repeat (8) @(negedge clk);
        chk(!dev_rd_n, "R6 strobe held while not ready", dev_rd_n, 0);
        dd_in = 16'h2222; dev_iordy = 1'b1;
        da = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (done) begin da = k; break; end
        end
        chk(da != 0, "R6 completes after ready", da, 1);
        chk(rdata == 16'h2222, "R4 data at strobe rise", rdata, 16'h2222);
        @(negedge clk);

        // R7 ready ignored in DMA
        dev_iordy = 1'b0;
        run_cycle(1'b0, 1'b1, 1'b0, 3'd0, 16'h4444, 1, 2, 1, da, sn, on, sb);
        chk(da == 5, "R7 DMA ignores ready", da, 5);
        dev_iordy = 1'b1;

        // R8 DMA waits for request
        t_setup = 8'd1; t_active = 8'd1; t_recover = 8'd1;
        req_write = 1; req_dma = 1; dev_dmarq = 1'b0; req_valid = 1'b1;
        repeat (5) @(negedge clk);
        chk(!busy && dev_dmack_n && dev_wr_n, "R8 held off without request", busy, 0);
        dev_dmarq = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        chk(busy && !dev_dmack_n, "R8 starts on request", dev_dmack_n, 0);
        repeat (5) @(negedge clk);
        dev_dmarq = 1'b0;

        // R9 request while busy ignored
        t_setup = 8'd2; t_active = 8'd3; t_recover = 8'd2;
        req_write = 0; req_dma = 0; req_blk = 0; req_addr = 3'd2; req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        req_addr = 3'd5; req_blk = 1; req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        chk(dev_addr == 3'd2 && !dev_cs0_n, "R9 busy ignores request", dev_addr, 2);
        da = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (done) begin da = k; break; end
        end
        @(negedge clk);
        chk(!done && !busy, "R9 done single pulse", {done, busy}, 0);
        repeat (3) @(negedge clk);
        chk(dev_rd_n && dev_cs1_n, "R9 no late start", dev_cs1_n, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule